// File: doc/BRIEF.md
# Inset Picture Border Overlay

This block sits in a YIQ pixel stream and paints a coloured rectangular border around an inset sub-picture. Each pixel beat carries its horizontal pixel position and vertical line position from the raster timing, together with its Y, I and Q samples. Configuration inputs give the outer rectangle of the border, a separate band thickness for each of the four edges, the luma and chroma border colour, and a flat backdrop colour. Any pixel inside the outer rectangle but outside the rectangle shrunk inward by the edge thicknesses is replaced by the border colour. Every other pixel passes through unchanged, with one exception: when the backdrop select is set, pixels in the enclosed area take the backdrop colour instead of the live image.

The border luma level has full 8-bit precision. Each border chroma level is only 4 bits wide and is placed in the upper half of the 8-bit chroma sample, with zeros below. Pixels enter through a valid/ready input and leave through a valid/ready output. A beat is taken when `in_valid` and `in_ready` are both high at a clock edge, and is presented on the output from the next cycle on. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The configuration inputs are sampled when a beat is accepted and must be held steady while traffic flows.

Top module: `frame_overlay`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: A beat in the border band leaves with Y equal to `cfg_frm_y`. I and Q are the 4-bit levels `cfg_frm_i` and `cfg_frm_q` shifted left by 4 (low nibble zero). `out_border` is 1 for that beat.
- R3: The outer rectangle is inclusive: `cfg_h_start <= in_hpos <= cfg_h_stop` and `cfg_v_start <= in_vpos <= cfg_v_stop`.
- R4: The band thickness is set per edge. The left band covers `cfg_h_start .. cfg_h_start+cfg_w_left-1` and the right band covers `cfg_h_stop-cfg_w_right+1 .. cfg_h_stop`. The top and bottom bands follow the same rule with `cfg_w_top` and `cfg_w_bottom`. A thickness of 0 gives no band on that edge.
- R5: A pixel inside the shrunk inner rectangle passes the live image when `cfg_bg_sel`=0. When `cfg_bg_sel`=1 it takes `cfg_bg_y`, `cfg_bg_i` and `cfg_bg_q`. In both cases `out_border` is 0.
- R6: With `cfg_en`=0 every beat passes through unchanged with `out_border`=0, and the backdrop is not applied.
- R7: An accepted beat is presented on the output one cycle after the clock edge that accepted it, with `out_valid` high. Beats leave in arrival order.
- R8: While `out_valid`=1 and `out_ready`=0 the output data and flag hold steady. `in_ready` is high exactly when the output register is empty or `out_ready` is high.
- R9: A pixel outside the outer rectangle passes through unchanged with `out_border`=0.
- R10: When the edge thicknesses meet or overlap, so that the inner rectangle is empty, every pixel of the outer rectangle is border.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Border enable |
| cfg_bg_sel | input | 1 | 1: enclosed area shows backdrop colour |
| cfg_h_start | input | 12 | Outer left pixel position |
| cfg_h_stop | input | 12 | Outer right pixel position |
| cfg_v_start | input | 10 | Outer top line |
| cfg_v_stop | input | 10 | Outer bottom line |
| cfg_w_left | input | 4 | Left band thickness |
| cfg_w_right | input | 4 | Right band thickness |
| cfg_w_top | input | 4 | Top band thickness |
| cfg_w_bottom | input | 4 | Bottom band thickness |
| cfg_frm_y | input | 8 | Border luma level |
| cfg_frm_i | input | 4 | Border I level (coarse) |
| cfg_frm_q | input | 4 | Border Q level (coarse) |
| cfg_bg_y | input | 8 | Backdrop luma |
| cfg_bg_i | input | 8 | Backdrop I |
| cfg_bg_q | input | 8 | Backdrop Q |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_hpos | input | 12 | Pixel position of the beat |
| in_vpos | input | 10 | Line position of the beat |
| in_y | input | 8 | Input luma |
| in_i | input | 8 | Input I |
| in_q | input | 8 | Input Q |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the beat |
| out_y | output | 8 | Output luma |
| out_i | output | 8 | Output I |
| out_q | output | 8 | Output Q |
| out_border | output | 1 | Output beat lies in the border band |

## Verification
Pixel data and the border flag are both due one cycle after the edge that accepts a beat. Under back-pressure they stay on the output until the edge at which `out_ready` is seen high. The bench therefore records the expected beat at the moment of acceptance, not at a fixed cycle count, and compares it when the output handshake completes, with all sampling done at the falling edge. During stall phases it also compares each held output beat with the one from the previous falling edge, so that any change while `out_ready` is low is caught.

// File: rtl/frame_overlay_pkg.sv
package frame_overlay_pkg;

  // Which source feeds an output pixel
  typedef enum logic [1:0] {
    SRC_LIVE     = 2'd0,
    SRC_FRAME    = 2'd1,
    SRC_BACKDROP = 2'd2
  } pix_src_e;

endpackage

// File: rtl/frame_span.sv
// One axis of the border geometry: outer span and inward-shrunk span.
module frame_span #(
  parameter int PW = 12,
  parameter int EW = 4
) (
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] lo,
  input  logic [PW-1:0] hi,
  input  logic [EW-1:0] w_lo,
  input  logic [EW-1:0] w_hi,
  output logic          in_outer,
  output logic          in_inner
);
  localparam int XW = PW + 1;

  logic [XW-1:0] pos_x, lo_x, hi_x, wlo_x, whi_x;

  always_comb begin
    pos_x = {1'b0, pos};
    lo_x  = {1'b0, lo};
    hi_x  = {1'b0, hi};
    wlo_x = XW'(w_lo);
    whi_x = XW'(w_hi);
    in_outer = (pos >= lo) && (pos <= hi);
    // widened sums avoid wrap when a thickness exceeds the span
    in_inner = in_outer && (pos_x >= lo_x + wlo_x) && (pos_x + whi_x <= hi_x);
  end
endmodule

// File: rtl/frame_mixer.sv
// Chooses live, border or backdrop value per channel.
module frame_mixer
  import frame_overlay_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  pix_src_e      src,
  input  logic [DW-1:0] live_y,
  input  logic [DW-1:0] live_i,
  input  logic [DW-1:0] live_q,
  input  logic [DW-1:0] frm_y,
  input  logic [CW-1:0] frm_i,
  input  logic [CW-1:0] frm_q,
  input  logic [DW-1:0] bg_y,
  input  logic [DW-1:0] bg_i,
  input  logic [DW-1:0] bg_q,
  output logic [DW-1:0] mix_y,
  output logic [DW-1:0] mix_i,
  output logic [DW-1:0] mix_q
);
  localparam int PADW = DW - CW;

  logic [DW-1:0] live_c [2];
  logic [CW-1:0] frm_c  [2];
  logic [DW-1:0] bg_c   [2];
  logic [DW-1:0] mix_c  [2];

  assign live_c[0] = live_i;
  assign live_c[1] = live_q;
  assign frm_c[0]  = frm_i;
  assign frm_c[1]  = frm_q;
  assign bg_c[0]   = bg_i;
  assign bg_c[1]   = bg_q;

  always_comb begin
    unique case (src)
      SRC_FRAME:    mix_y = frm_y;
      SRC_BACKDROP: mix_y = bg_y;
      default:      mix_y = live_y;
    endcase
  end

  for (genvar c = 0; c < 2; c++) begin : g_chroma
    logic [DW-1:0] frm_wide;
    assign frm_wide = {frm_c[c], {PADW{1'b0}}};
    always_comb begin
      unique case (src)
        SRC_FRAME:    mix_c[c] = frm_wide;
        SRC_BACKDROP: mix_c[c] = bg_c[c];
        default:      mix_c[c] = live_c[c];
      endcase
    end
  end

  assign mix_i = mix_c[0];
  assign mix_q = mix_c[1];
endmodule

// File: rtl/frame_outreg.sv
// Single register stage with valid/ready flow control.
module frame_outreg #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (s_ready) begin
      vld_q <= s_valid;
      if (s_valid) dat_q <= s_data;
    end
  end
endmodule

// File: rtl/frame_overlay.sv
module frame_overlay
  import frame_overlay_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 10,
  parameter int EW = 4,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_bg_sel,
  input  logic [HW-1:0] cfg_h_start,
  input  logic [HW-1:0] cfg_h_stop,
  input  logic [VW-1:0] cfg_v_start,
  input  logic [VW-1:0] cfg_v_stop,
  input  logic [EW-1:0] cfg_w_left,
  input  logic [EW-1:0] cfg_w_right,
  input  logic [EW-1:0] cfg_w_top,
  input  logic [EW-1:0] cfg_w_bottom,
  input  logic [DW-1:0] cfg_frm_y,
  input  logic [CW-1:0] cfg_frm_i,
  input  logic [CW-1:0] cfg_frm_q,
  input  logic [DW-1:0] cfg_bg_y,
  input  logic [DW-1:0] cfg_bg_i,
  input  logic [DW-1:0] cfg_bg_q,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [HW-1:0] in_hpos,
  input  logic [VW-1:0] in_vpos,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic          out_border
);
  localparam int BW = 3 * DW + 1;

  logic     h_outer, h_inner, v_outer, v_inner;
  logic     band, enclosed;
  pix_src_e src;
  logic [DW-1:0] mix_y, mix_i, mix_q;
  logic [BW-1:0] pipe_in, pipe_out;

  frame_span #(.PW(HW), .EW(EW)) u_hspan (
    .pos(in_hpos), .lo(cfg_h_start), .hi(cfg_h_stop),
    .w_lo(cfg_w_left), .w_hi(cfg_w_right),
    .in_outer(h_outer), .in_inner(h_inner)
  );

  frame_span #(.PW(VW), .EW(EW)) u_vspan (
    .pos(in_vpos), .lo(cfg_v_start), .hi(cfg_v_stop),
    .w_lo(cfg_w_top), .w_hi(cfg_w_bottom),
    .in_outer(v_outer), .in_inner(v_inner)
  );

  always_comb begin
    band     = cfg_en && h_outer && v_outer && !(h_inner && v_inner);
    enclosed = cfg_en && h_inner && v_inner;
    if (band)                        src = SRC_FRAME;
    else if (enclosed && cfg_bg_sel) src = SRC_BACKDROP;
    else                             src = SRC_LIVE;
  end

  frame_mixer #(.DW(DW), .CW(CW)) u_mix (
    .src(src),
    .live_y(in_y), .live_i(in_i), .live_q(in_q),
    .frm_y(cfg_frm_y), .frm_i(cfg_frm_i), .frm_q(cfg_frm_q),
    .bg_y(cfg_bg_y), .bg_i(cfg_bg_i), .bg_q(cfg_bg_q),
    .mix_y(mix_y), .mix_i(mix_i), .mix_q(mix_q)
  );

  assign pipe_in = {band, mix_y, mix_i, mix_q};

  frame_outreg #(.W(BW)) u_oreg (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(pipe_in),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(pipe_out)
  );

  assign out_border = pipe_out[BW-1];
  assign out_y      = pipe_out[3*DW-1:2*DW];
  assign out_i      = pipe_out[2*DW-1:DW];
  assign out_q      = pipe_out[DW-1:0];
endmodule

// File: rtl/frame_overlay_chk.sv
module frame_overlay_chk #(
  parameter int HW = 12,
  parameter int VW = 10,
  parameter int EW = 4,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic [HW-1:0] cfg_h_start,
  input logic          in_valid,
  input logic          in_ready,
  input logic [HW-1:0] in_hpos,
  input logic [DW-1:0] in_y,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_i,
  input logic [DW-1:0] out_q,
  input logic          out_border
);
  localparam int PADW = DW - CW;

  // R1: first cycle out of reset shows an empty output
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid);

  // R7: an accepted beat is valid on the output next cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8: stalled output holds steady
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(out_i)
                                   && $stable(out_q) && $stable(out_border)));

  // R6: disabled border never flags a beat
  a_r6_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_en) |=> !out_border);

  // R9: left of the outer rectangle the pixel is untouched
  a_r9_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_hpos < cfg_h_start)) |=>
      (!out_border && out_y == $past(in_y)));

  // R2: border chroma carries zero low bits
  a_r2_chroma_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_border) |-> (out_i[PADW-1:0] == '0 && out_q[PADW-1:0] == '0));
endmodule

bind frame_overlay frame_overlay_chk #(.HW(HW), .VW(VW), .EW(EW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/sim_frame_overlay.sv
`timescale 1ns/1ps
module sim_frame_overlay;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_en, cfg_bg_sel;
  logic [11:0] cfg_h_start, cfg_h_stop;
  logic [9:0]  cfg_v_start, cfg_v_stop;
  logic [3:0]  cfg_w_left, cfg_w_right, cfg_w_top, cfg_w_bottom;
  logic [7:0]  cfg_frm_y, cfg_bg_y, cfg_bg_i, cfg_bg_q;
  logic [3:0]  cfg_frm_i, cfg_frm_q;
  logic        in_valid = 1'b0, in_ready;
  logic [11:0] in_hpos = '0;
  logic [9:0]  in_vpos = '0;
  logic [7:0]  in_y = '0, in_i = '0, in_q = '0;
  logic        out_valid, out_ready = 1'b1, out_border;
  logic [7:0]  out_y, out_i, out_q;

  frame_overlay u0 (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  logic [24:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // downstream readiness changes just after the edge
  initial forever begin
    @(posedge clk);
    #2 out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  function automatic logic [24:0] model(input int h, input int v,
                                        input logic [7:0] y, input logic [7:0] i,
                                        input logic [7:0] q);
    bit outer, inner;
    outer = h >= cfg_h_start && h <= cfg_h_stop && v >= cfg_v_start && v <= cfg_v_stop;
    inner = outer && h >= cfg_h_start + cfg_w_left && h <= cfg_h_stop - cfg_w_right
                  && v >= cfg_v_start + cfg_w_top && v <= cfg_v_stop - cfg_w_bottom;
    if (!cfg_en) return {1'b0, y, i, q};
    if (outer && !inner) return {1'b1, cfg_frm_y, cfg_frm_i, 4'h0, cfg_frm_q, 4'h0};
    if (inner && cfg_bg_sel) return {1'b0, cfg_bg_y, cfg_bg_i, cfg_bg_q};
    return {1'b0, y, i, q};
  endfunction

  task automatic send(input int h, input int v, input logic [7:0] y,
                      input logic [7:0] i, input logic [7:0] q, input string tag);
    @(negedge clk);
    in_hpos = 12'(h); in_vpos = 10'(v);
    in_y = y; in_i = i; in_q = q;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(h, v, y, i, q));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [24:0] prev_beat;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (prev_stall) begin
        checks++;
        if ({out_border, out_y, out_i, out_q} !== prev_beat) begin
          fails++;
          $display("FAIL R8 held beat changed: actual %h expected %h",
                   {out_border, out_y, out_i, out_q}, prev_beat);
        end
      end
      prev_beat  = {out_border, out_y, out_i, out_q};
      prev_stall = !out_ready;
      if (out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected beat: actual %h expected none", prev_beat);
        end else begin
          logic [24:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (prev_beat !== e) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, prev_beat, e);
          end
        end
      end
    end else begin
      prev_stall = 1'b0;
    end
  end

  initial begin
    wait (cyc >= 50000);
    fails++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cfg_en = 1'b1; cfg_bg_sel = 1'b0;
    cfg_h_start = 12'd100; cfg_h_stop = 12'd200;
    cfg_v_start = 10'd20;  cfg_v_stop = 10'd60;
    cfg_w_left = 4'd3; cfg_w_right = 4'd5; cfg_w_top = 4'd2; cfg_w_bottom = 4'd4;
    cfg_frm_y = 8'hE1; cfg_frm_i = 4'hA; cfg_frm_q = 4'h5;
    cfg_bg_y = 8'h10; cfg_bg_i = 8'h80; cfg_bg_q = 8'h7F;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state: actual valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end

    // corners of the outer rectangle and edge bands
    send(99, 30, 8'h11, 8'h22, 8'h33, "R9 left of frame");
    send(100, 30, 8'h11, 8'h22, 8'h33, "R3 outer left inclusive");
    send(102, 30, 8'h11, 8'h22, 8'h33, "R4 last left band pixel");
    send(103, 30, 8'h44, 8'h55, 8'h66, "R5 first interior pixel live");
    send(195, 30, 8'h44, 8'h55, 8'h66, "R5 last interior pixel live");
    send(196, 30, 8'h11, 8'h22, 8'h33, "R4 first right band pixel");
    send(200, 30, 8'h11, 8'h22, 8'h33, "R3 outer right inclusive");
    send(201, 30, 8'h11, 8'h22, 8'h33, "R9 right of frame");
    send(150, 19, 8'h12, 8'h34, 8'h56, "R9 above frame");
    send(150, 20, 8'h12, 8'h34, 8'h56, "R2 top band colour");
    send(150, 21, 8'h12, 8'h34, 8'h56, "R4 top band second line");
    send(150, 22, 8'h12, 8'h34, 8'h56, "R4 first interior line");
    send(150, 56, 8'h12, 8'h34, 8'h56, "R4 last interior line");
    send(150, 57, 8'h12, 8'h34, 8'h56, "R4 bottom band first line");
    send(150, 60, 8'h12, 8'h34, 8'h56, "R3 outer bottom inclusive");
    send(150, 61, 8'h12, 8'h34, 8'h56, "R9 below frame");

    // back-pressure across a whole line sweep
    stall_mode = 1'b1;
    for (int h = 95; h <= 205; h += 5)
      send(h, 40, 8'(h), 8'(h + 1), 8'(h + 2), "R8 sweep under stall");
    drain();
    stall_mode = 1'b0;

    // backdrop in the enclosed area
    cfg_bg_sel = 1'b1;
    send(150, 40, 8'h99, 8'h98, 8'h97, "R5 backdrop interior");
    send(101, 40, 8'h99, 8'h98, 8'h97, "R2 band wins over backdrop");
    send(50, 40, 8'h99, 8'h98, 8'h97, "R9 backdrop not outside");
    drain();

    // disabled border
    cfg_en = 1'b0;
    send(100, 20, 8'h01, 8'h02, 8'h03, "R6 disabled band pixel");
    send(150, 40, 8'h04, 8'h05, 8'h06, "R6 disabled interior no backdrop");
    drain();

    // zero thickness on left and top
    cfg_en = 1'b1; cfg_bg_sel = 1'b0;
    cfg_w_left = 4'd0; cfg_w_top = 4'd0;
    send(100, 30, 8'h21, 8'h22, 8'h23, "R4 zero left thickness");
    send(150, 20, 8'h21, 8'h22, 8'h23, "R4 zero top thickness");
    drain();

    // thicknesses overlap: whole outer rectangle is border
    cfg_h_start = 12'd10; cfg_h_stop = 12'd14; cfg_w_left = 4'd15;
    cfg_v_start = 10'd5;  cfg_v_stop = 10'd7;  cfg_w_top = 4'd1; cfg_w_bottom = 4'd1;
    cfg_frm_y = 8'h3C; cfg_frm_i = 4'hF; cfg_frm_q = 4'h1;
    for (int h = 10; h <= 14; h++)
      send(h, 6, 8'h70, 8'h71, 8'h72, "R10 empty interior all band");
    send(15, 6, 8'h70, 8'h71, 8'h72, "R9 past right edge");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule